// File: doc/BRIEF.md
# Toggle-Addressed Random Access Test Cell Grid

This block holds a parameterised set of state bits arranged on a square grid. Any single bit can be reached for test. In normal operation every bit captures its functional next-state input on each clock. When the global test enable is high, the bits stop following their functional inputs and hold their values. A binary address register then picks one bit. The upper address bits drive a row decoder and the lower bits drive a column decoder. Only the bit where the active row line and the active column line cross can be acted on.

No data wire carries test values into the bits. A write strobe inverts the selected bit. To reach any target pattern, the tester inverts only the bits whose present value differs from the target. A read strobe copies the selected bit onto a single registered scan output and raises a valid flag for one cycle, so observation is also random access. Grid positions at or beyond the number of bits hold no cell. Addresses that point there select nothing.

A small controller state machine tracks the mode. It has three states. CT_FUNC is used while test_en is low. CT_IDLE is used in test mode when no read was issued. CT_READOUT lasts for the cycle that follows an accepted read. Transitions are evaluated on every clock in this order. From any state, test_en low goes to CT_FUNC. From any state, test_en high with rd_stb goes to CT_READOUT. From any state, test_en high without rd_stb goes to CT_IDLE.

Top module: `toggle_scan_array`

## Requirements
- R1: Reset clears every cell, the address register, scan_out and scan_vld to 0, and puts the controller in CT_FUNC.
- R2: The address is ADDR_W = ceil(log2(N_CELLS)) bits wide. The lower ceil(ADDR_W/2) bits form the column field and the remaining upper bits form the row field. Address value a selects cell index a, which is func_q bit a.
- R3: While test_en is low, every cell loads its func_d bit on each clock. wr_stb, rd_stb and addr_ld have no effect on the cells or on the address register.
- R4: With test_en high, a clock edge with wr_stb high inverts exactly the cell selected by the address register, and every other cell keeps its value.
- R5: With test_en high and wr_stb low, all cells hold their values and func_d is ignored.
- R6: With test_en high, a clock edge with rd_stb high makes scan_out equal to the selected cell's value and scan_vld equal to 1 during the following cycle. A read never changes any cell. In every other cycle scan_vld and scan_out are 0.
- R7: An address at or above N_CELLS selects no cell. A write there changes nothing, and a read there returns scan_out 0 with scan_vld 1.
- R8: With test_en high, addr_ld loads addr_in into the address register at the clock edge. A write or read issued in the same cycle uses the previous address.
- R9: When wr_stb and rd_stb are both high in one cycle, the read returns the cell's value from before the inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Global test mode enable |
| func_d | input | N_CELLS | Functional next-state inputs, one per cell |
| addr_ld | input | 1 | Load addr_in into the address register |
| addr_in | input | ADDR_W | Cell address to load |
| wr_stb | input | 1 | Invert the addressed cell |
| rd_stb | input | 1 | Read the addressed cell |
| func_q | output | N_CELLS | Stored cell values |
| scan_out | output | 1 | Registered value of the cell that was read |
| scan_vld | output | 1 | scan_out holds a read result |

## Verification
Functional loading is exercised with alternating and complementary func_d patterns while all strobes are active. This separates correct loading from leakage of test actions into normal mode. A target pattern is then built by inverting only the differing cells. Every address, including the empty grid positions, is read back. This shows whether the row and column fields are decoded in the right place and whether absent cells stay silent. Same-cycle combinations of load with write and of write with read separate old-address and old-value behaviour from new. A long randomized run, compared against a behavioural model on every clock, covers mixes of modes and strobes.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [1:0] {
        CT_FUNC    = 2'd0,
        CT_IDLE    = 2'd1,
        CT_READOUT = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/tsa_onehot.sv
module tsa_onehot #(
    parameter int W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     code,
    output logic [(1<<W)-1:0] sel
);
    localparam int LINES = 1 << W;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign sel[i] = (code == W'(i));
    end

    // R2: exactly one select line per decoder is active
    p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
endmodule

// File: rtl/tsa_cell.sv
module tsa_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic d,
    input  logic tgl,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (!test_en)
            q <= d;
        else if (tgl)
            q <= ~q;
    end

    p_func_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> q == $past(d));
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && tgl) |=> q != $past(q));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !tgl) |=> $stable(q));
endmodule

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
    import tsa_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_stb,
    input  logic              rd_bit,
    output logic [ADDR_W-1:0] addr_q,
    output logic              scan_out,
    output logic              scan_vld
);
    ctl_st_e st, st_nx;

    always_comb begin
        unique case (st)
            CT_FUNC, CT_IDLE, CT_READOUT: begin
                if (!test_en)
                    st_nx = CT_FUNC;
                else if (rd_stb)
                    st_nx = CT_READOUT;
                else
                    st_nx = CT_IDLE;
            end
            default: st_nx = CT_FUNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= CT_FUNC;
        else
            st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            scan_out <= 1'b0;
        end else begin
            if (test_en && addr_ld)
                addr_q <= addr_in;
            scan_out <= (st_nx == CT_READOUT) ? rd_bit : 1'b0;
        end
    end

    assign scan_vld = (st == CT_READOUT);

    p_vld_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_vld |-> $past(test_en && rd_stb));
    p_addr_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> $stable(addr_q));
    p_quiet_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_vld |-> !scan_out);
endmodule

// File: rtl/toggle_scan_array.sv
module toggle_scan_array #(
    parameter int N_CELLS = 12,
    localparam int ADDR_W = (N_CELLS > 4) ? $clog2(N_CELLS) : 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_en,
    input  logic [N_CELLS-1:0] func_d,
    input  logic               addr_ld,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               wr_stb,
    input  logic               rd_stb,
    output logic [N_CELLS-1:0] func_q,
    output logic               scan_out,
    output logic               scan_vld
);
    localparam int COL_W = (ADDR_W + 1) / 2;
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int NCOLS = 1 << COL_W;
    localparam int NROWS = 1 << ROW_W;
    localparam int GRID  = NROWS * NCOLS;

    logic [ADDR_W-1:0] addr_q;
    logic [NROWS-1:0]  row_sel;
    logic [NCOLS-1:0]  col_sel;
    logic [GRID-1:0]   grid_q;
    logic [GRID-1:0]   tgl_vec;
    logic [NROWS-1:0]  row_hit;
    logic              wr_act;
    logic              rd_bit;

    assign wr_act = test_en && wr_stb;

    tsa_onehot #(.W(ROW_W)) u_row_dec (
        .clk(clk), .rst_n(rst_n),
        .code(addr_q[ADDR_W-1:COL_W]), .sel(row_sel));

    tsa_onehot #(.W(COL_W)) u_col_dec (
        .clk(clk), .rst_n(rst_n),
        .code(addr_q[COL_W-1:0]), .sel(col_sel));

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        for (genvar c = 0; c < NCOLS; c++) begin : g_col
            localparam int IDX = r * NCOLS + c;
            assign tgl_vec[IDX] = wr_act && row_sel[r] && col_sel[c];
            if (IDX < N_CELLS) begin : g_cell
                tsa_cell u_cell (
                    .clk(clk), .rst_n(rst_n), .test_en(test_en),
                    .d(func_d[IDX]), .tgl(tgl_vec[IDX]), .q(func_q[IDX]));
                assign grid_q[IDX] = func_q[IDX];
            end else begin : g_empty
                assign grid_q[IDX] = 1'b0;
            end
        end
        assign row_hit[r] = |(grid_q[r*NCOLS +: NCOLS] & col_sel);
    end

    assign rd_bit = |(row_hit & row_sel);

    tsa_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .test_en(test_en),
        .addr_ld(addr_ld), .addr_in(addr_in), .rd_stb(rd_stb),
        .rd_bit(rd_bit), .addr_q(addr_q),
        .scan_out(scan_out), .scan_vld(scan_vld));

    p_single_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgl_vec) <= 1);
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && rd_stb && addr_q >= ADDR_W'(N_CELLS)) |=> (scan_vld && !scan_out));
    p_empty_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && addr_q >= ADDR_W'(N_CELLS)) |=> $stable(func_q));
endmodule

// File: tb/tb_toggle_scan_array.sv
module tb_toggle_scan_array;
    localparam int N  = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic [N-1:0]  func_d = '0;
    logic          addr_ld = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          wr_stb = 1'b0;
    logic          rd_stb = 1'b0;
    logic [N-1:0]  func_q;
    logic          scan_out;
    logic          scan_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_cells;
    int           m_addr;
    logic         m_out;
    logic         m_vld;

    always #4 clk = ~clk;

    toggle_scan_array #(.N_CELLS(N)) dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .func_d(func_d),
        .addr_ld(addr_ld), .addr_in(addr_in), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .func_q(func_q), .scan_out(scan_out),
        .scan_vld(scan_vld));

    task automatic compare(string tag);
        checks++;
        if (func_q !== m_cells) begin
            errors++;
            $display("FAIL %s func_q actual=%h expected=%h", tag, func_q, m_cells);
        end
        checks++;
        if (scan_vld !== m_vld || scan_out !== m_out) begin
            errors++;
            $display("FAIL %s vld/out actual=%b/%b expected=%b/%b",
                     tag, scan_vld, scan_out, m_vld, m_out);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check at next falling edge
    task automatic cyc(input bit te, input bit ld, input int a, input bit wr,
                       input bit rd, input logic [N-1:0] d, input string tag);
        test_en = te; addr_ld = ld; addr_in = AW'(a);
        wr_stb = wr; rd_stb = rd; func_d = d;
        m_vld = te && rd;
        m_out = (te && rd && m_addr < N) ? m_cells[m_addr] : 1'b0;
        if (!te) m_cells = d;
        else if (wr && m_addr < N) m_cells[m_addr] = ~m_cells[m_addr];
        if (te && ld) m_addr = a;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] target;
        m_cells = '0; m_addr = 0; m_out = 0; m_vld = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        // R1: address cleared, read cell 0 after load in functional mode
        cyc(0, 0, 0, 0, 0, 12'h001, "R1");
        cyc(1, 0, 0, 0, 1, 12'hFFF, "R1");

        // R3: functional loading ignores strobes and address load
        cyc(0, 1, 5, 1, 1, 12'hA5A, "R3");
        cyc(0, 1, 9, 1, 1, 12'h5A5, "R3");
        cyc(0, 0, 0, 0, 0, 12'h000, "R3");
        cyc(1, 0, 0, 0, 1, 12'h000, "R3");

        // R5: test mode holds against changing func_d
        cyc(0, 0, 0, 0, 0, 12'h3C3, "R5");
        cyc(1, 0, 0, 0, 0, 12'hFFF, "R5");
        cyc(1, 0, 0, 0, 0, 12'h000, "R5");

        // R4 and R2: reach a target by toggling only differing cells
        target = 12'h9C6;
        for (int i = 0; i < N; i++) begin
            if (m_cells[i] != target[i]) begin
                cyc(1, 1, i, 0, 0, 12'h0, "R2");
                cyc(1, 0, 0, 1, 0, 12'h0, "R4");
            end
        end
        checks++;
        if (func_q !== target) begin
            errors++;
            $display("FAIL R4 pattern actual=%h expected=%h", func_q, target);
        end

        // R6, R7: read every address including empty grid positions
        for (int a = 0; a < 16; a++) begin
            cyc(1, 1, a, 0, 0, 12'h0, "R2");
            cyc(1, 0, 0, 0, 1, 12'h0, a < N ? "R6" : "R7");
        end
        // R7: writes to empty positions change nothing
        for (int a = N; a < 16; a++) begin
            cyc(1, 1, a, 0, 0, 12'h0, "R7");
            cyc(1, 0, 0, 1, 1, 12'h0, "R7");
        end

        // R8: load with write uses old address
        cyc(1, 1, 3, 0, 0, 12'h0, "R8");
        cyc(1, 1, 7, 1, 0, 12'h0, "R8");
        cyc(1, 0, 0, 0, 1, 12'h0, "R8");
        // R9: write with read returns the pre-inversion value
        cyc(1, 0, 0, 1, 1, 12'h0, "R9");
        cyc(1, 0, 0, 0, 1, 12'h0, "R9");
        // R6: back-to-back reads keep valid high and cells unchanged
        cyc(1, 1, 1, 0, 1, 12'h0, "R6");
        cyc(1, 0, 0, 0, 1, 12'h0, "R6");

        // Randomized mix against the model
        for (int k = 0; k < 600; k++) begin
            cyc(($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 16,
                $urandom % 2, $urandom % 2, N'($urandom), "R4");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule